// File: doc/BRIEF.md
# Memory Slot Occupancy Gate

This block keeps a running count of the occupied entries in a load queue and in a store queue, and tells the dispatch stage whether the instruction it is about to send can be accepted. The dispatch stage presents a query made of two flags: whether the instruction reads memory and whether it writes memory. The block answers with a two-bit status code. The code is zero when the instruction fits. Otherwise it names the queue that has no room.

Entries are claimed with one-cycle take strobes, one per queue. Every load and every load barrier takes one load entry. Every store and every store barrier takes one store entry. Entries are given back with free strobes. Load entries are freed at retirement and store entries at commit. Both capacities are run-time configuration inputs. A capacity of zero means that queue has no bound and never reports full. Each queue also shows empty and full flags, and a sticky error flag. The error flag is raised when an entry is freed while the queue is empty.

Top module: `mem_slot_gate`

## Requirements
- R1: The status code is 0 (available), 1 (load queue full) or 2 (store queue full). A query with neither the read flag nor the write flag set always returns 0.
- R2: A query with only the read flag set returns 1 when the load queue is full and 0 otherwise, whatever the store queue holds.
- R3: A query with only the write flag set returns 2 when the store queue is full and 0 otherwise, whatever the load queue holds.
- R4: A query with both flags set returns 1 if the load queue is full, even when the store queue is full too. It returns 2 if only the store queue is full.
- R5: A queue's full flag is high only when its capacity input is nonzero and its used count equals that capacity. A capacity of 0 never gives full.
- R6: A queue's empty flag is high exactly when its used count is zero.
- R7: A take strobe raises the used count by one, and a free strobe lowers it by one. The change is visible from the cycle after the strobe.
- R8: A take and a free on the same queue in the same cycle leave its count unchanged.
- R9: A free on an empty queue leaves the count at zero and sets that queue's error flag. The flag stays set until reset, and later takes still count normally.
- R10: After reset both counts are zero, both queues show empty and not full, both error flags are low and the status is 0.
- R11: Used counts are 8 bits wide and saturate at 255. A take at 255 leaves the count at 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_cap | input | 8 | Load queue capacity, 0 = unbounded |
| st_cap | input | 8 | Store queue capacity, 0 = unbounded |
| q_rd | input | 1 | Queried instruction reads memory (or is a load barrier) |
| q_wr | input | 1 | Queried instruction writes memory (or is a store barrier) |
| ld_take | input | 1 | Claim one load queue entry |
| st_take | input | 1 | Claim one store queue entry |
| ld_free | input | 1 | Return one load queue entry (retirement) |
| st_free | input | 1 | Return one store queue entry (commit) |
| status | output | 2 | 0 available, 1 load queue full, 2 store queue full |
| ld_empty | output | 1 | Load queue holds no entries |
| ld_full | output | 1 | Load queue at its nonzero capacity |
| st_empty | output | 1 | Store queue holds no entries |
| st_full | output | 1 | Store queue at its nonzero capacity |
| ld_err | output | 1 | Sticky: a load entry was freed while empty |
| st_err | output | 1 | Sticky: a store entry was freed while empty |

## Verification
The status is queried with each of the four flag combinations. The queues are set up as only load full, only store full, both full and neither full. Together these show whether the code follows the right queue, and whether the load queue wins when both are full. The used count is read back through the full flag by stepping the capacity input to a guess. A match can come only from the exact count, so single-step drift from simultaneous strobes, underflow or saturation shows up. A zero capacity with entries held shows whether the unbounded case really disables full.

// File: rtl/mem_slot_pkg.sv
`timescale 1ns/1ps
package mem_slot_pkg;
   typedef enum logic [1:0] {
      SLOT_OK      = 2'd0,
      SLOT_LD_FULL = 2'd1,
      SLOT_ST_FULL = 2'd2
   } slot_status_e;

   localparam int NUM_QUEUES = 2;
   localparam int Q_LOAD     = 0;
   localparam int Q_STORE    = 1;
endpackage

// File: rtl/slot_counter.sv
`timescale 1ns/1ps
module slot_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cap,
   input  logic             take,
   input  logic             free,
   output logic             empty,
   output logic             full,
   output logic             underflow
);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;
   localparam logic [CNT_W-1:0] CNT_ZERO = '0;

   initial begin
      if (CNT_W < 2) $fatal(1, "slot_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] used_q, used_d;
   logic             err_q, err_d;

   always_comb begin
      used_d = used_q;
      err_d  = err_q;
      unique case ({take, free})
         2'b10: if (used_q != CNT_MAX) used_d = used_q + 1'b1;
         2'b01: begin
            if (used_q == CNT_ZERO) err_d = 1'b1;
            else                    used_d = used_q - 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         used_q <= CNT_ZERO;
         err_q  <= 1'b0;
      end else begin
         used_q <= used_d;
         err_q  <= err_d;
      end
   end

   assign empty     = (used_q == CNT_ZERO);
   assign full      = (cap != CNT_ZERO) && (used_q == cap);
   assign underflow = err_q;

   assert_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !free && used_q != CNT_MAX) |=> used_q == CNT_W'($past(used_q) + 1'b1));
   assert_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (free && !take && used_q != CNT_ZERO) |=> used_q == CNT_W'($past(used_q) - 1'b1));
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (take && free) |=> $stable(used_q));
   assert_uflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (free && !take && empty) |=> (underflow && empty));
   assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> underflow);
   assert_sat_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !free && used_q == CNT_MAX) |=> used_q == CNT_MAX);
endmodule

// File: rtl/slot_status_sel.sv
`timescale 1ns/1ps
module slot_status_sel
   import mem_slot_pkg::*;
#(
   parameter int NQ = NUM_QUEUES
) (
   input  logic [NQ-1:0] want,
   input  logic [NQ-1:0] full,
   output slot_status_e  status
);
   logic [NQ-1:0] blocked;
   assign blocked = want & full;

   always_comb begin
      status = SLOT_OK;
      for (int i = NQ - 1; i >= 0; i--) begin
         if (blocked[i]) status = slot_status_e'(i + 1);
      end
   end
endmodule

// File: rtl/mem_slot_gate.sv
`timescale 1ns/1ps
module mem_slot_gate
   import mem_slot_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] ld_cap,
   input  logic [CNT_W-1:0] st_cap,
   input  logic             q_rd,
   input  logic             q_wr,
   input  logic             ld_take,
   input  logic             st_take,
   input  logic             ld_free,
   input  logic             st_free,
   output logic [1:0]       status,
   output logic             ld_empty,
   output logic             ld_full,
   output logic             st_empty,
   output logic             st_full,
   output logic             ld_err,
   output logic             st_err
);
   localparam int NQ = NUM_QUEUES;

   logic [NQ-1:0][CNT_W-1:0] cap_a;
   logic [NQ-1:0]            take_a, free_a, want_a;
   logic [NQ-1:0]            empty_a, full_a, err_a;
   slot_status_e             status_e;

   assign cap_a[Q_LOAD]   = ld_cap;
   assign cap_a[Q_STORE]  = st_cap;
   assign take_a[Q_LOAD]  = ld_take;
   assign take_a[Q_STORE] = st_take;
   assign free_a[Q_LOAD]  = ld_free;
   assign free_a[Q_STORE] = st_free;
   assign want_a[Q_LOAD]  = q_rd;
   assign want_a[Q_STORE] = q_wr;

   for (genvar g = 0; g < NQ; g++) begin : g_queue
      slot_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk       (clk),
         .rst_n     (rst_n),
         .cap       (cap_a[g]),
         .take      (take_a[g]),
         .free      (free_a[g]),
         .empty     (empty_a[g]),
         .full      (full_a[g]),
         .underflow (err_a[g])
      );
   end

   slot_status_sel #(.NQ(NQ)) u_sel (
      .want   (want_a),
      .full   (full_a),
      .status (status_e)
   );

   assign status   = status_e;
   assign ld_empty = empty_a[Q_LOAD];
   assign ld_full  = full_a[Q_LOAD];
   assign st_empty = empty_a[Q_STORE];
   assign st_full  = full_a[Q_STORE];
   assign ld_err   = err_a[Q_LOAD];
   assign st_err   = err_a[Q_STORE];

   assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!q_rd && !q_wr) |-> status == 2'd0);
   assert_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (q_rd && !q_wr) |-> status == (ld_full ? 2'd1 : 2'd0));
   assert_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (q_wr && !q_rd) |-> status == (st_full ? 2'd2 : 2'd0));
   assert_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (q_rd && q_wr && ld_full) |-> status == 2'd1);
   assert_unbound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_cap == '0) |-> !ld_full);
   assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_empty && st_cap != '0) |-> !st_full);
   assert_rst_R10: assert property (@(posedge clk)
      !rst_n |=> (ld_empty && st_empty && !ld_err && !st_err));
endmodule

// File: tb/mem_slot_gate_bench.sv
`timescale 1ns/1ps
module mem_slot_gate_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] ld_cap = 8'd0, st_cap = 8'd0;
   logic       q_rd = 1'b0, q_wr = 1'b0;
   logic       ld_take = 1'b0, st_take = 1'b0, ld_free = 1'b0, st_free = 1'b0;
   logic [1:0] status;
   logic       ld_empty, ld_full, st_empty, st_full, ld_err, st_err;
   int         n_chk = 0, n_fail = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   mem_slot_gate u_mem_slot_gate (
      .clk(clk), .rst_n(rst_n), .ld_cap(ld_cap), .st_cap(st_cap),
      .q_rd(q_rd), .q_wr(q_wr), .ld_take(ld_take), .st_take(st_take),
      .ld_free(ld_free), .st_free(st_free), .status(status),
      .ld_empty(ld_empty), .ld_full(ld_full), .st_empty(st_empty),
      .st_full(st_full), .ld_err(ld_err), .st_err(st_err)
   );

   task automatic check(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic step(input logic lt, input logic lf, input logic stk, input logic sf);
      @(negedge clk);
      ld_take = lt; ld_free = lf; st_take = stk; st_free = sf;
      @(negedge clk);
      ld_take = 1'b0; ld_free = 1'b0; st_take = 1'b0; st_free = 1'b0;
   endtask

   task automatic query(input logic rd, input logic wr, input int exp, input string req);
      q_rd = rd; q_wr = wr;
      #1;
      check(req, status, exp);
      q_rd = 1'b0; q_wr = 1'b0;
      #1;
   endtask

   // Count read back through the full flag by probing the capacity input.
   task automatic ld_count_is(input int n, input string req);
      logic [7:0] keep;
      keep = ld_cap;
      ld_cap = 8'(n);
      #1;
      if (n == 0) check(req, ld_empty, 1);
      else begin
         check(req, ld_full, 1);
         check(req, ld_empty, 0);
      end
      ld_cap = keep;
      #1;
   endtask

   task automatic st_count_is(input int n, input string req);
      logic [7:0] keep;
      keep = st_cap;
      st_cap = 8'(n);
      #1;
      if (n == 0) check(req, st_empty, 1);
      else begin
         check(req, st_full, 1);
         check(req, st_empty, 0);
      end
      st_cap = keep;
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      ld_cap = 8'd4; st_cap = 8'd4;
      #1;
      check("R10 ld_empty", ld_empty, 1);
      check("R10 st_empty", st_empty, 1);
      check("R10 ld_full", ld_full, 0);
      check("R10 st_full", st_full, 0);
      check("R10 ld_err", ld_err, 0);
      check("R10 st_err", st_err, 0);
      query(1'b1, 1'b1, 0, "R10 status");
   endtask

   task automatic t_load();
      do_reset();
      ld_cap = 8'd3; st_cap = 8'd2;
      step(1, 0, 0, 0);
      ld_count_is(1, "R7 one take");
      query(1'b1, 1'b0, 0, "R2 not yet full");
      step(1, 0, 0, 0);
      step(1, 0, 0, 0);
      #1;
      check("R5 ld_full at cap", ld_full, 1);
      check("R6 ld not empty", ld_empty, 0);
      query(1'b1, 1'b0, 1, "R2 load full");
      query(1'b0, 1'b1, 0, "R3 store ignores load full");
      query(1'b0, 1'b0, 0, "R1 no memory access");
      step(0, 1, 0, 0);
      ld_count_is(2, "R7 free");
      query(1'b1, 1'b0, 0, "R2 after free");
   endtask

   task automatic t_store();
      do_reset();
      ld_cap = 8'd1; st_cap = 8'd2;
      step(1, 0, 1, 0);
      step(0, 0, 1, 0);
      #1;
      check("R5 st_full at cap", st_full, 1);
      check("R5 ld_full at cap", ld_full, 1);
      ld_cap = 8'd5;
      query(1'b0, 1'b1, 2, "R3 store full");
      query(1'b1, 1'b0, 0, "R2 load ignores store full");
      query(1'b1, 1'b1, 2, "R4 only store full");
      ld_cap = 8'd1;
      query(1'b1, 1'b1, 1, "R4 load wins when both full");
      query(1'b0, 1'b0, 0, "R1 both full, no access");
   endtask

   task automatic t_unbounded();
      do_reset();
      ld_cap = 8'd0; st_cap = 8'd0;
      step(1, 0, 1, 0);
      step(1, 0, 0, 0);
      #1;
      check("R5 zero cap ld not full", ld_full, 0);
      check("R5 zero cap st not full", st_full, 0);
      check("R6 ld not empty", ld_empty, 0);
      query(1'b1, 1'b1, 0, "R5 unbounded available");
      ld_count_is(2, "R5 count under zero cap");
      st_count_is(1, "R5 store count under zero cap");
   endtask

   task automatic t_same_cycle();
      do_reset();
      step(1, 0, 1, 0);
      step(1, 1, 1, 1);
      ld_count_is(1, "R8 load both strobes");
      st_count_is(1, "R8 store both strobes");
      step(0, 1, 0, 1);
      #1;
      check("R6 ld empty again", ld_empty, 1);
      check("R6 st empty again", st_empty, 1);
      step(1, 1, 0, 0);
      #1;
      check("R8 take+free on empty no error", ld_err, 0);
   endtask

   task automatic t_underflow();
      do_reset();
      step(0, 1, 0, 0);
      #1;
      check("R9 ld_err set", ld_err, 1);
      check("R9 st_err untouched", st_err, 0);
      check("R9 ld stays empty", ld_empty, 1);
      step(1, 0, 0, 1);
      ld_count_is(1, "R9 count after error");
      check("R9 ld_err sticky", ld_err, 1);
      check("R9 st_err set", st_err, 1);
      check("R9 st stays empty", st_empty, 1);
   endtask

   task automatic t_saturate();
      do_reset();
      for (int i = 0; i < 260; i++) step(1, 0, 0, 0);
      ld_count_is(255, "R11 saturated count");
      ld_cap = 8'd254;
      #1;
      check("R5 equality only", ld_full, 0);
      step(0, 1, 0, 0);
      ld_count_is(254, "R11 free from max");
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_load();
      t_store();
      t_unbounded();
      t_same_cycle();
      t_underflow();
      t_saturate();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 50000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule